// File: doc/BRIEF.md
# Single-Buffer Serial Port Peripheral

A compact asynchronous serial port that sits on a simple 32-bit register bus with an address, a write strobe, a read strobe, write data and combinational read data. It carries one transmitter and one receiver. Each has a holding register one byte deep. The line format is fixed: one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity, and the line idles high. A divider register sets how many system clocks each serial bit lasts.

Software writes bytes to the data register and reads received bytes from the same offset. It watches the status register and can drive the port from three interrupt lines: transmit, receive, and a combined overrun line. Each event sets a sticky flag, and software clears a flag by writing a one to its bit. Register offsets, from byte address 0: data 0x00, status 0x04, control 0x08, flags 0x0C, divider 0x10.

Top module: `ser_port`

## Requirements
- R1: After reset the status (0x04), control (0x08) and flag (0x0C) registers read 0, the divider (0x10) reads 16, `txd_o` is high and all three interrupt outputs are low.
- R2: Writing 0x00 while status bit 0 (transmit full) is clear stores the byte and sets bit 0. When control bit 0 (transmit enable) is set and the shifter is idle, the byte moves to the shifter. This clears status bit 0 and sets flag bit 0. The byte is then sent as a low start bit, the eight data bits LSB first, and a high stop bit, each lasting divider clocks.
- R3: Writing 0x00 while status bit 0 is set leaves the held byte unchanged and sets transmit overrun, which shows in both status bit 2 and flag bit 2.
- R4: With control bit 1 (receive enable) set, a frame with a high stop bit stores its byte, sets status bit 1 (receive full) and sets flag bit 1. A read of 0x00 returns the byte in bits 7:0 and clears status bit 1.
- R5: A frame whose stop bit samples low is discarded: status bit 1 stays clear.
- R6: A complete frame that arrives while status bit 1 is set sets receive overrun, shown in status bit 3 and flag bit 3. The byte already stored is kept.
- R7: Writing a 1 to a bit of 0x0C clears that flag. Writing a 0 leaves it unchanged. The overrun bits of status and flags are the same two flags.
- R8: `irq_tx_o` is flag bit 0 gated by control bit 2. `irq_rx_o` is flag bit 1 gated by control bit 3. `irq_ovr_o` is (flag bit 2 and control bit 4) or (flag bit 3 and control bit 5).
- R9: The divider is 21 bits wide. A written value below 16 is stored as 16, and write bits above bit 20 are dropped.
- R10: With control bit 0 clear, a held byte is not sent and `txd_o` stays high. With control bit 1 clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (a read of 0x00 consumes the received byte) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line, idles high |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_ovr_o | output | 1 | Combined overrun interrupt |

## Verification
The bench holds a byte while transmit is disabled and then writes a second byte on top of it. The first byte must be the one that goes out. A design that let the overrun write replace the held byte would send the wrong value. A second received frame that lands on a full buffer must raise the overrun without disturbing the stored byte. A frame with a low stop bit must leave the buffer empty, or the design would accept garbage. The bench writes zero to the flag register and expects no effect, then writes one and expects the flag to clear, which catches clear logic built on the wrong polarity. It writes divider values below the minimum and above 21 bits. It also runs a loopback at a second divider value, which exposes off-by-one errors in the half-bit and full-bit sample counts.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_BUF  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_IRQF = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h10;

  localparam int CFG_TX_EN  = 0;
  localparam int CFG_RX_EN  = 1;
  localparam int CFG_TX_IE  = 2;
  localparam int CFG_RX_IE  = 3;
  localparam int CFG_TXO_IE = 4;
  localparam int CFG_RXO_IE = 5;
  localparam int CFG_W      = 6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
endpackage

// File: rtl/ser_port_tx.sv
module ser_port_tx #(
  parameter int DIV_W = 21,
  parameter int BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [BITS-1:0]  data_i,
  output logic             busy_o,
  output logic             txd_o
);
  localparam int FRAME = BITS + 2;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [FRAME-1:0] sh_q;
  logic [CNT_W-1:0] left_q;
  logic [DIV_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      left_q <= CNT_W'(FRAME);
      cnt_q  <= div_i - 1'b1;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        sh_q   <= {1'b1, sh_q[FRAME-1:1]};
        cnt_q  <= div_i - 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/ser_port_rx.sv
module ser_port_rx
  import ser_port_pkg::*;
#(
  parameter int DIV_W = 21,
  parameter int BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic [BITS-1:0]  data_o
);
  localparam int IDX_W = $clog2(BITS);

  logic [2:0]       sy_q;
  rx_st_e           st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [BITS-1:0]  sh_q;
  logic             rxs, falling, tick;

  assign rxs     = sy_q[1];
  assign falling = sy_q[2] & ~sy_q[1];
  assign tick    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sy_q <= '1;
    else         sy_q <= {sy_q[1:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (!en_i) begin
      st_q <= RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: if (falling) begin
          st_q  <= RX_START;
          cnt_q <= (div_i >> 1) - 1'b1;
        end
        RX_START: if (tick) begin
          if (!rxs) begin
            st_q  <= RX_DATA;
            cnt_q <= div_i - 1'b1;
            idx_q <= '0;
          end else begin
            st_q <= RX_IDLE;  // glitch, not a start bit
          end
        end else cnt_q <= cnt_q - 1'b1;
        RX_DATA: if (tick) begin
          sh_q  <= {rxs, sh_q[BITS-1:1]};
          cnt_q <= div_i - 1'b1;
          if (idx_q == IDX_W'(BITS - 1)) st_q <= RX_STOP;
          else idx_q <= idx_q + 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        RX_STOP: if (tick) st_q <= RX_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = en_i && (st_q == RX_STOP) && tick && rxs;
  assign data_o = sh_q;
endmodule

// File: rtl/ser_port.sv
module ser_port
  import ser_port_pkg::*;
#(
  parameter int DIV_W   = 21,
  parameter int DIV_MIN = 16,
  parameter int BITS    = 8,
  parameter int BUS_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_ovr_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [BITS-1:0]  tx_hold_q, rx_buf_q, rx_byte;
  logic tx_full_q, rx_full_q, tx_flag_q, rx_flag_q, tx_ovr_q, rx_ovr_q;
  logic wr_buf, wr_stat, wr_cfg, wr_irqf, wr_div, rd_buf;
  logic tx_busy, tx_take, rx_done, rx_store;
  logic [3:0] clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:DIV_W];

  assign wr_buf  = we_i && (addr_i == OFS_BUF);
  assign wr_stat = we_i && (addr_i == OFS_STAT);
  assign wr_cfg  = we_i && (addr_i == OFS_CFG);
  assign wr_irqf = we_i && (addr_i == OFS_IRQF);
  assign wr_div  = we_i && (addr_i == OFS_DIV);
  assign rd_buf  = re_i && (addr_i == OFS_BUF);

  // overrun bits may be cleared through either status or flag offset
  assign clr = (wr_irqf ? wdata_i[3:0] : 4'b0) | (wr_stat ? {wdata_i[3:2], 2'b00} : 4'b0);

  assign tx_take  = tx_full_q && cfg_q[CFG_TX_EN] && !tx_busy;
  assign rx_store = rx_done && !rx_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      div_q     <= DIV_W'(DIV_MIN);
      tx_hold_q <= '0;
      rx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
      tx_ovr_q  <= 1'b0;
      rx_ovr_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wdata_i[CFG_W-1:0];
      if (wr_div)
        div_q <= (wdata_i[DIV_W-1:0] < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : wdata_i[DIV_W-1:0];

      if (tx_take) tx_full_q <= 1'b0;
      if (wr_buf && !tx_full_q) begin
        tx_hold_q <= wdata_i[BITS-1:0];
        tx_full_q <= 1'b1;
      end

      if (rx_store) begin
        rx_buf_q  <= rx_byte;
        rx_full_q <= 1'b1;
      end else if (rd_buf) begin
        rx_full_q <= 1'b0;
      end

      tx_flag_q <= tx_take                | (tx_flag_q & ~clr[0]);
      rx_flag_q <= rx_store               | (rx_flag_q & ~clr[1]);
      tx_ovr_q  <= (wr_buf && tx_full_q)  | (tx_ovr_q  & ~clr[2]);
      rx_ovr_q  <= (rx_done && rx_full_q) | (rx_ovr_q  & ~clr[3]);
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_BUF:  rdata_o = BUS_W'(rx_buf_q);
      OFS_STAT: rdata_o = BUS_W'({rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q});
      OFS_CFG:  rdata_o = BUS_W'(cfg_q);
      OFS_IRQF: rdata_o = BUS_W'({rx_ovr_q, tx_ovr_q, rx_flag_q, tx_flag_q});
      OFS_DIV:  rdata_o = BUS_W'(div_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_tx_o  = tx_flag_q & cfg_q[CFG_TX_IE];
  assign irq_rx_o  = rx_flag_q & cfg_q[CFG_RX_IE];
  assign irq_ovr_o = (tx_ovr_q & cfg_q[CFG_TXO_IE]) | (rx_ovr_q & cfg_q[CFG_RXO_IE]);

  ser_port_tx #(.DIV_W(DIV_W), .BITS(BITS)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .load_i (tx_take),
    .data_i (tx_hold_q),
    .busy_o (tx_busy),
    .txd_o  (txd_o)
  );

  ser_port_rx #(.DIV_W(DIV_W), .BITS(BITS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_q[CFG_RX_EN]),
    .div_i  (div_q),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_byte)
  );
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk #(
  parameter int DIV_W   = 21,
  parameter int DIV_MIN = 16,
  parameter int BITS    = 8,
  parameter int CFG_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txd_o,
  input logic             tx_busy,
  input logic             tx_full_q,
  input logic             tx_flag_q,
  input logic             tx_ovr_q,
  input logic [BITS-1:0]  tx_hold_q,
  input logic             rx_full_q,
  input logic             rx_flag_q,
  input logic             rx_ovr_q,
  input logic [BITS-1:0]  rx_buf_q,
  input logic [CFG_W-1:0] cfg_q,
  input logic [DIV_W-1:0] div_q
);
  p_take_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_full_q) |-> tx_flag_q);

  p_ovr_keeps_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ovr_q) |-> $stable(tx_hold_q));

  p_store_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> rx_flag_q);

  p_ovr_keeps_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovr_q) |-> $stable(rx_buf_q));

  p_div_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q >= DIV_W'(DIV_MIN));

  p_idle_line_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  p_rx_off_no_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[1] |=> !$rose(rx_full_q));
endmodule

bind ser_port ser_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .txd_o     (txd_o),
  .tx_busy   (tx_busy),
  .tx_full_q (tx_full_q),
  .tx_flag_q (tx_flag_q),
  .tx_ovr_q  (tx_ovr_q),
  .tx_hold_q (tx_hold_q),
  .rx_full_q (rx_full_q),
  .rx_flag_q (rx_flag_q),
  .rx_ovr_q  (rx_ovr_q),
  .rx_buf_q  (rx_buf_q),
  .cfg_q     (cfg_q),
  .div_q     (div_q)
);

// File: tb/sim_ser_port.sv
module sim_ser_port;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_BUF = 5'h00, A_STAT = 5'h04, A_CFG = 5'h08, A_IRQF = 5'h0C, A_DIV = 5'h10;
  // bit 8: stop bit high, bits 7:0: byte
  localparam logic [8:0] RXV [0:5] = '{9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h03C, 9'h181};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        rxd, txd, irq_tx, irq_rx, irq_ovr;
  logic        loop = 1'b0, rxd_drv = 1'b1;
  int          total = 0, bad = 0, cur_div = 16;
  logic [31:0] v;
  logic [7:0]  tb;
  logic        tok;

  always #(CLK_P/2) clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  ser_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_ovr_o(irq_ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop_hi);
    logic [9:0] fr;
    fr = {stop_hi, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rxd_drv = fr[i];
      repeat (cur_div) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic grab(output logic [7:0] b, output logic ok);
    int n;
    n = 0;
    ok = 1'b1;
    b = '0;
    while (txd === 1'b1 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) ok = 1'b0;
    repeat (cur_div/2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (cur_div) @(negedge clk);
      b[i] = txd;
    end
    repeat (cur_div) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0);
    rd(A_IRQF, v); chk("R1 irqf", v, 32'h0);
    rd(A_DIV, v);  chk("R1 div", v, 32'd16);
    chk("R1 lines", {28'b0, txd, irq_tx, irq_rx, irq_ovr}, 32'h8);

    // R9 divider limits
    wr(A_DIV, 32'd5);        rd(A_DIV, v); chk("R9 below min", v, 32'd16);
    wr(A_DIV, 32'hFFFFFFFF); rd(A_DIV, v); chk("R9 width", v, 32'h1FFFFF);
    wr(A_DIV, 32'd16);

    // R10 receiver disabled
    send(8'h77, 1'b1);
    rd(A_STAT, v); chk("R10 rx off", v[1], 1'b0);

    // R4 R5 R8 receive vector walk
    wr(A_CFG, 32'h0A);
    for (int i = 0; i < 6; i++) begin
      send(RXV[i][7:0], RXV[i][8]);
      rd(A_STAT, v); chk("R4/R5 rx full", v[1], RXV[i][8]);
      if (RXV[i][8]) begin
        rd(A_IRQF, v); chk("R4 rx flag", v[1], 1'b1);
        chk("R8 irq_rx", irq_rx, 1'b1);
        rd(A_BUF, v);  chk("R4 rx byte", v, {24'b0, RXV[i][7:0]});
        rd(A_STAT, v); chk("R4 rx cleared", v[1], 1'b0);
        wr(A_IRQF, 32'h2);
        chk("R7 rx flag clr", irq_rx, 1'b0);
      end
    end

    // R6 receive overrun
    wr(A_CFG, 32'h2A);
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    rd(A_STAT, v); chk("R6 stat ovr", v[3:1], 3'b101);
    chk("R8 irq_ovr rx", irq_ovr, 1'b1);
    rd(A_BUF, v);  chk("R6 kept byte", v, 32'h11);
    wr(A_IRQF, 32'h0);
    rd(A_IRQF, v); chk("R7 zero no effect", v[3], 1'b1);
    wr(A_IRQF, 32'h8);
    rd(A_STAT, v); chk("R7 ovr cleared", v[3], 1'b0);
    chk("R7 irq_ovr low", irq_ovr, 1'b0);
    wr(A_IRQF, 32'h2);

    // R10 R3 transmit hold and overrun
    wr(A_CFG, 32'h0);
    wr(A_BUF, 32'hA5);
    repeat (40) @(negedge clk);
    chk("R10 tx held line", txd, 1'b1);
    rd(A_STAT, v); chk("R2 tx full", v[0], 1'b1);
    wr(A_BUF, 32'h3C);
    rd(A_STAT, v); chk("R3 stat ovr", v[2:0], 3'b101);
    rd(A_IRQF, v); chk("R3 flag ovr", v[2], 1'b1);
    chk("R8 irq_ovr gated off", irq_ovr, 1'b0);
    wr(A_CFG, 32'h15);
    chk("R8 irq_ovr tx", irq_ovr, 1'b1);
    grab(tb, tok);
    chk("R2 frame shape", tok, 1'b1);
    chk("R3 held byte sent", tb, 8'hA5);
    rd(A_STAT, v); chk("R2 tx empty", v[0], 1'b0);
    rd(A_IRQF, v); chk("R2 tx flag", v[0], 1'b1);
    chk("R8 irq_tx", irq_tx, 1'b1);
    wr(A_IRQF, 32'h5);
    rd(A_IRQF, v); chk("R7 tx clear", v, 32'h0);

    // R2 R4 R9 loopback at a larger divider, interrupts masked
    repeat (cur_div * 2) @(negedge clk);
    wr(A_DIV, 32'd32); cur_div = 32;
    loop = 1'b1;
    wr(A_CFG, 32'h03);
    wr(A_BUF, 32'hC3);
    repeat (11 * 32 + 10) @(negedge clk);
    rd(A_IRQF, v); chk("R4 loop flags", v, 32'h3);
    chk("R8 irqs masked", {irq_tx, irq_rx, irq_ovr}, 3'b000);
    rd(A_BUF, v);  chk("R9 loop byte", v, 32'hC3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule